// File: doc/BRIEF.md
# Prescaled Up-Counting Timer with Reload Shadow

This block is a free-running up-counter driven through a small register port on one clock. A programmable divider turns the system clock into counter ticks. The counter climbs from zero to a reload limit, returns to zero on the following tick and raises an update flag. Software can start and stop the counter, force an update that restarts everything from zero, and clear the sticky status flags.

The divider ratio always waits for an update before it is used. The reload limit either acts at once or waits for the next update, depending on a control bit. Software reconfigures the block by stopping the counter and waiting until the run-status bit reads zero. It then writes the divider and the limit, forces an update, waits for the completion flag, clears the flags and starts the counter again.

The register port is plain control: a write strobe with address and data, and a combinational read selected by its own address. No data flows in a stream, so there is no valid/ready handshake and no back-pressure.

Top module: `prescaled_uptimer`

## Requirements
- R1: After reset the counter reads 0, the status reads 0, the run bit reads 0, the divider reads 0 and the reload limit reads all ones. The register addresses are 0 control, 1 run, 2 event, 3 status, 4 divider, 5 reload and 6 counter.
- R2: While running, the counter advances by one every divider+1 clock cycles. The first tick comes on the (divider+1)-th counting cycle after the run bit is set.
- R3: On a tick where the counter equals the active reload limit, the counter becomes 0 and status bit 0 (update) is set.
- R4: Run-status bit 0 of the run register rises one cycle after the counter is enabled and falls one cycle after it is disabled. While it is low the counter holds its value.
- R5: Writing the run register with bit 1 set disables the counter, and stop wins over start. Writing it with only bit 0 set enables the counter. Control bit 0 is the same enable.
- R6: Writing 1 to event bit 0 forces an update one cycle later. The divider phase and the counter go to 0, the divider and reload shadows load, and status bit 1 (update done) is set.
- R7: Status flags are write-one-to-clear: bit 0 update, bit 1 update done, bit 2 started, bit 3 stopped. A flag set in the same cycle as a clear stays set.
- R8: With control bit 1 set, a new reload value takes effect only at the next update. With it clear, the new value takes effect at once.
- R9: A new divider value takes effect only at the next update.
- R10: With control bit 2 set, a wrap returns the counter to 0 but raises no update flag and loads no shadow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | DATA_W | Read data for rd_addr (combinational) |

## Verification
The assertions take for granted that the counter reaches its limit by counting up. A reload value below the current count, written with the shadow off, would send the counter through its whole range, and the wrap checks do not cover that case. The stimulus writes every limit while the counter is stopped or before it has reached the new value. It reconfigures only after the run bit has read zero, and it writes one register at a time.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int ADDR_W = 3;
  localparam int NFLAG  = 4;

  typedef enum logic [ADDR_W-1:0] {
    RA_CTRL = 3'd0,
    RA_RUN  = 3'd1,
    RA_EVT  = 3'd2,
    RA_STS  = 3'd3,
    RA_DIV  = 3'd4,
    RA_LIM  = 3'd5,
    RA_CNT  = 3'd6
  } reg_addr_e;

  localparam int F_UPD   = 0;
  localparam int F_DONE  = 1;
  localparam int F_START = 2;
  localparam int F_STOP  = 3;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              running,
  input  logic [CNT_W-1:0]  count,
  input  logic              set_upd,
  input  logic              set_start,
  input  logic              set_stop,
  output logic              en_req,
  output logic              lim_buffered,
  output logic              upd_off,
  output logic              force_upd,
  output logic [DIV_W-1:0]  div_pre,
  output logic [CNT_W-1:0]  lim_pre
);
  logic             w_ctrl, w_run, w_evt, w_sts, w_div, w_lim;
  logic [NFLAG-1:0] flags, flag_set, flag_clr;

  assign w_ctrl = wr_en && (wr_addr == RA_CTRL);
  assign w_run  = wr_en && (wr_addr == RA_RUN);
  assign w_evt  = wr_en && (wr_addr == RA_EVT);
  assign w_sts  = wr_en && (wr_addr == RA_STS);
  assign w_div  = wr_en && (wr_addr == RA_DIV);
  assign w_lim  = wr_en && (wr_addr == RA_LIM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_req       <= 1'b0;
      lim_buffered <= 1'b0;
      upd_off      <= 1'b0;
    end else if (w_ctrl) begin
      en_req       <= wr_data[0];
      lim_buffered <= wr_data[1];
      upd_off      <= wr_data[2];
    end else if (w_run) begin
      if (wr_data[1])      en_req <= 1'b0;
      else if (wr_data[0]) en_req <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      force_upd <= 1'b0;
      div_pre   <= '0;
      lim_pre   <= '1;
    end else begin
      force_upd <= w_evt && wr_data[0];
      if (w_div) div_pre <= wr_data[DIV_W-1:0];
      if (w_lim) lim_pre <= wr_data[CNT_W-1:0];
    end
  end

  always_comb begin
    flag_set         = '0;
    flag_set[F_UPD]  = set_upd;
    flag_set[F_DONE] = force_upd;
    flag_set[F_START]= set_start;
    flag_set[F_STOP] = set_stop;
    flag_clr         = w_sts ? wr_data[NFLAG-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~flag_clr) | flag_set;
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      RA_CTRL: rd_data[2:0]       = {upd_off, lim_buffered, en_req};
      RA_RUN:  rd_data[0]         = running;
      RA_STS:  rd_data[NFLAG-1:0] = flags;
      RA_DIV:  rd_data[DIV_W-1:0] = div_pre;
      RA_LIM:  rd_data[CNT_W-1:0] = lim_pre;
      RA_CNT:  rd_data[CNT_W-1:0] = count;
      default: rd_data            = '0;
    endcase
  end

  p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (w_sts && wr_data[F_UPD] && !set_upd) |=> !flags[F_UPD]);
  p_done_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    force_upd |=> flags[F_DONE]);
endmodule

// File: rtl/tmr_runctl.sv
module tmr_runctl (
  input  logic clk,
  input  logic rst_n,
  input  logic en_req,
  output logic running,
  output logic rose,
  output logic fell
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) running <= 1'b0;
    else        running <= en_req;
  end

  assign rose = en_req && !running;
  assign fell = !en_req && running;

  p_run_edges_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rose |=> running);
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             running,
  input  logic             force_upd,
  input  logic             wrap_upd,
  input  logic [DIV_W-1:0] div_pre,
  output logic             tick
);
  logic [DIV_W-1:0] phase, div_sh;
  logic             load;

  assign load = force_upd || wrap_upd;
  assign tick = running && !force_upd && (phase == div_sh);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= '0;
      div_sh <= '0;
    end else begin
      if (load) div_sh <= div_pre;
      if (force_upd)    phase <= '0;
      else if (tick)    phase <= '0;
      else if (running) phase <= phase + 1'b1;
    end
  end

  p_phase_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    phase <= div_sh);
  p_div_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(div_sh));
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             force_upd,
  input  logic             upd_off,
  input  logic             lim_buffered,
  input  logic [CNT_W-1:0] lim_pre,
  output logic [CNT_W-1:0] count,
  output logic             wrap_upd
);
  logic [CNT_W-1:0] lim_sh, lim_eff;
  logic             at_lim;

  assign lim_eff  = lim_buffered ? lim_sh : lim_pre;
  assign at_lim   = (count == lim_eff);
  assign wrap_upd = tick && at_lim && !upd_off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count  <= '0;
      lim_sh <= '1;
    end else begin
      if (force_upd || wrap_upd || !lim_buffered) lim_sh <= lim_pre;
      if (force_upd)      count <= '0;
      else if (tick)      count <= at_lim ? '0 : count + 1'b1;
    end
  end

  p_wrap_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && at_lim && !force_upd) |=> (count == '0));
  p_force_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    force_upd |=> (count == '0));
  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !force_upd) |=> $stable(count));
  p_shadow_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lim_buffered && !force_upd && !wrap_upd) |=> $stable(lim_sh));
endmodule

// File: rtl/prescaled_uptimer.sv
module prescaled_uptimer
  import tmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [2:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic             en_req, lim_buffered, upd_off, force_upd;
  logic             running, rose, fell, tick, wrap_upd;
  logic [DIV_W-1:0] div_pre;
  logic [CNT_W-1:0] lim_pre, count;

  tmr_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .running(running), .count(count), .set_upd(wrap_upd),
    .set_start(rose), .set_stop(fell), .en_req(en_req),
    .lim_buffered(lim_buffered), .upd_off(upd_off), .force_upd(force_upd),
    .div_pre(div_pre), .lim_pre(lim_pre)
  );

  tmr_runctl u_run (
    .clk(clk), .rst_n(rst_n), .en_req(en_req),
    .running(running), .rose(rose), .fell(fell)
  );

  tmr_prescaler #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .running(running), .force_upd(force_upd),
    .wrap_upd(wrap_upd), .div_pre(div_pre), .tick(tick)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .force_upd(force_upd),
    .upd_off(upd_off), .lim_buffered(lim_buffered), .lim_pre(lim_pre),
    .count(count), .wrap_upd(wrap_upd)
  );

  p_no_tick_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !tick);
  p_quiet_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    upd_off |-> !wrap_upd);
endmodule

// File: tb/prescaled_uptimer_test.sv
module prescaled_uptimer_test;
  localparam int DW = 32;
  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [2:0]    wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [2:0]    rd_addr = '0;
  logic [DW-1:0] rd_data;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  localparam logic [2:0] A_CTRL = 3'd0, A_RUN = 3'd1, A_EVT = 3'd2,
                         A_STS = 3'd3, A_DIV = 3'd4, A_LIM = 3'd5, A_CNT = 3'd6;

  prescaled_uptimer uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [DW-1:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setup(input int ctrl, input int dv, input int lim);
    wr(A_RUN, 2);
    idle(3);
    wr(A_CTRL, ctrl);
    wr(A_DIV, dv);
    wr(A_LIM, lim);
    wr(A_EVT, 1);
    idle(2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] v, v2;
    idle(2);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    rd(A_CNT, v);  chk("R1 count", v, 0);
    rd(A_STS, v);  chk("R1 status", v, 0);
    rd(A_RUN, v);  chk("R1 run", v, 0);
    rd(A_DIV, v);  chk("R1 divider", v, 0);
    rd(A_LIM, v);  chk("R1 reload", v, 32'h0000_FFFF);

    // R2 R3 R5 sweep over divider and limit
    for (int p = 0; p < 4; p++) begin
      for (int a = 0; a < 5; a++) begin
        int j, m, t;
        setup(0, p, a);
        wr(A_STS, 15);
        wr(A_RUN, 1);
        j = 2 * (p + 1) * (a + 1) + p + 2 - ((p + a) % 3);
        idle(j);
        m = j - 1;
        t = m / (p + 1);
        rd(A_CNT, v); chk("R2 count", v, t % (a + 1));
        rd(A_STS, v); chk("R3 update flag", v & 1, (t >= a + 1) ? 1 : 0);
        wr(A_RUN, 2);
        idle(2);
        rd(A_RUN, v); chk("R5 stopped", v, 0);
        rd(A_CNT, v);
        idle(5);
        rd(A_CNT, v2); chk("R4 frozen", v2, v);
      end
    end

    // R4 run bit timing and R6 mid-run forced update
    setup(0, 0, 9);
    wr(A_STS, 15);
    wr(A_RUN, 1);
    rd(A_RUN, v); chk("R4 run not yet", v, 0);
    idle(1);
    rd(A_RUN, v); chk("R4 run high", v, 1);
    idle(4);
    wr(A_EVT, 1);
    idle(1);
    rd(A_CNT, v); chk("R6 count zero", v, 0);
    rd(A_STS, v); chk("R6 done flag", (v >> 1) & 1, 1);
    wr(A_RUN, 2);
    idle(1);
    rd(A_RUN, v); chk("R4 run low", v, 0);

    // R5 control bit 0 enables too
    wr(A_CTRL, 1);
    idle(1);
    rd(A_RUN, v); chk("R5 ctrl enable", v, 1);
    wr(A_RUN, 3);
    idle(1);
    rd(A_RUN, v); chk("R5 stop wins", v, 0);

    // R8 buffered reload
    setup(2, 0, 9);
    wr(A_LIM, 2);
    wr(A_STS, 15);
    wr(A_RUN, 1);
    idle(8);
    rd(A_CNT, v); chk("R8 old limit kept", v, 7);
    idle(10);
    rd(A_CNT, v); chk("R8 new limit after update", v, 1);

    // R8 immediate reload
    setup(0, 0, 9);
    wr(A_LIM, 2);
    wr(A_RUN, 1);
    idle(8);
    rd(A_CNT, v); chk("R8 immediate limit", v, 1);

    // R9 divider latched at update
    setup(0, 0, 1);
    wr(A_DIV, 2);
    wr(A_RUN, 1);
    idle(6);
    rd(A_CNT, v); chk("R9 count early", v, 1);
    idle(4);
    rd(A_CNT, v); chk("R9 count late", v, 0);

    // R10 quiet wrap
    setup(4, 0, 2);
    wr(A_DIV, 3);
    wr(A_STS, 15);
    wr(A_RUN, 1);
    idle(8);
    rd(A_CNT, v); chk("R10 count", v, 1);
    rd(A_STS, v); chk("R10 no update flag", v & 1, 0);

    // R7 write-one-to-clear
    wr(A_RUN, 2);
    idle(2);
    rd(A_STS, v); chk("R7 start and stop flags", v, 12);
    wr(A_EVT, 1);
    idle(1);
    rd(A_STS, v); chk("R7 done added", v, 14);
    wr(A_STS, 4);
    rd(A_STS, v); chk("R7 partial clear", v, 10);
    wr(A_STS, 15);
    rd(A_STS, v); chk("R7 full clear", v, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule